// File: doc/BRIEF.md
# Server cell flow controller

This block sits in the transmit path of a server that talks to a bufferless optical packet switch. Each outgoing packet arrives as a descriptor (byte length and destination label). The block turns the length into a number of fixed 1500-byte cells and books that many cells in a transceiver buffer of 50 000 bytes (33 whole cells). Packets wait in arrival order in a descriptor queue. A packet that does not fit is dropped and counted. Buffer overflow is the only way a packet is lost.

A slot strobe from the global time-slot schedule opens a transmit slot. In that slot the block emits one optical packet: up to five cells of the oldest packet, one cell per clock, all under that packet's label. It then holds until the switch answers. A positive answer (ACK) frees the sent cells. A negative answer (NACK) keeps them, bumps a retransmission counter, and makes the next slot carry exactly the same cells again. Only one optical packet per transceiver is ever in flight, so this buffer plays the part of the contention buffer that the switch does not have. The last cell of each packet is padded to full size: it carries a tail flag and the count of real bytes it holds.

The controller is one state machine with three states. **Idle** goes to **Send** on a slot strobe while a packet is buffered. **Send** stays in **Send** for each further cell of the burst and goes to **Wait** after the burst's last cell. **Wait** goes back to **Idle** on an ACK or a NACK.

Top module: `cfc_flow_ctrl`

## Requirements
- R1: A packet of L bytes occupies n = ceil(L/1500) cells, numbered 0..n-1 on `tx_cell_idx`. `tx_tail` is high only on cell n-1. `tx_bytes` is 1500 on every cell except cell n-1, which reports L-(n-1)*1500.
- R2: A slot strobe in Idle with a packet buffered starts a burst on the next clock. The burst is min(5, unacknowledged cells of the oldest packet) cells on consecutive cycles, beginning at its first unacknowledged cell. `tx_sop` marks the first cell, `tx_eop` the last, and `tx_label` holds that packet's label throughout.
- R3: An admitted packet adds n to `cells_used`, which never exceeds 33 (50 000 / 1500, rounded down).
- R4: A packet is dropped if n exceeds the free cells (33 - `cells_used`) or if 8 packets are already queued. A drop adds 1 to `drop_count`, leaves `cells_used` unchanged, and the packet is never sent. A descriptor with length 0 is ignored entirely.
- R5: An ACK (`ack_valid`=1, `ack_ok`=1) in Wait lowers `cells_used` by the burst size. The next slot continues with the following cells, or with the next packet once all cells of this one are acknowledged.
- R6: A NACK (`ack_valid`=1, `ack_ok`=0) in Wait adds 1 to `retx_count`, frees nothing, and the next slot resends the same cells with the same indices, flags and label.
- R7: A slot strobe during Send or Wait is ignored (no cell follows it). `ack_valid` outside Wait is ignored (`cells_used` and `retx_count` unchanged).
- R8: If an admission and an ACK release fall in the same cycle, `cells_used` becomes old + n - burst. The admission is judged against the occupancy before the release.
- R9: After reset `tx_valid` is 0, `cells_used`, `drop_count` and `retx_count` are 0, and the machine is in Idle.
- R10: Packets are sent in arrival order. No cell of a later packet is sent before every cell of the older one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet descriptor present this cycle |
| pkt_len | input | 16 (LEN_W) | Packet length in bytes |
| pkt_label | input | 6 (LBL_W) | Destination label of the packet |
| slot_strobe | input | 1 | Start of a transmit time slot |
| ack_valid | input | 1 | Switch answer present this cycle |
| ack_ok | input | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | A cell is on the transmit stream |
| tx_sop | output | 1 | First cell of the optical packet |
| tx_eop | output | 1 | Last cell of the optical packet |
| tx_tail | output | 1 | Cell ends its packet |
| tx_label | output | 6 (LBL_W) | Destination label of the optical packet |
| tx_cell_idx | output | 6 | Cell number within its packet |
| tx_bytes | output | 11 | Real bytes in this cell |
| cells_used | output | 6 | Cells booked in the buffer |
| drop_count | output | 16 (CNT_W) | Packets dropped on overflow |
| retx_count | output | 16 (CNT_W) | NACKs received |

## Verification
Admission of a new descriptor and release of cells on an ACK can land on the same clock edge, and both change the buffer occupancy. The bench provokes this twice, with the answer to a burst driven together with a packet. In the first case the buffer is exactly full, so the packet must be dropped even though cells are freed in that cycle. In the second case the packet fits the free space exactly. The verdict rests on `cells_used` and `drop_count` after the edge, and on the cells of the accepted packet later appearing in order. A slot strobe and an answer in the same Wait cycle are also driven, and no burst may follow.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } tx_state_e;
endpackage

// File: rtl/cfc_admit.sv
module cfc_admit #(
    parameter int LEN_W      = 16,
    parameter int CELL_BYTES = 1500,
    parameter int BUF_CELLS  = 33,
    parameter int OCC_W      = 6,
    parameter int BYTES_W    = 11
) (
    input  logic               pkt_valid,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [OCC_W-1:0]   used,
    input  logic               q_full,
    output logic               accept,
    output logic               drop,
    output logic [OCC_W-1:0]   ncells,
    output logic [BYTES_W-1:0] tail_bytes
);
    int need_i;
    int tail_i;
    int free_i;
    logic nonzero;

    always_comb begin
        need_i     = (int'(pkt_len) + CELL_BYTES - 1) / CELL_BYTES;
        tail_i     = (need_i == 0) ? 0 : int'(pkt_len) - (need_i - 1) * CELL_BYTES;
        free_i     = BUF_CELLS - int'(used);
        nonzero    = (pkt_len != '0);
        accept     = pkt_valid && nonzero && !q_full && (need_i <= free_i);
        drop       = pkt_valid && nonzero && !accept;
        ncells     = OCC_W'(need_i);
        tail_bytes = BYTES_W'(tail_i);
    end
endmodule

// File: rtl/cfc_pkt_queue.sv
module cfc_pkt_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/cfc_sender.sv
module cfc_sender
    import cfc_pkg::*;
#(
    parameter int LBL_W       = 6,
    parameter int OCC_W       = 6,
    parameter int BYTES_W     = 11,
    parameter int CELL_BYTES  = 1500,
    parameter int BURST_CELLS = 5,
    parameter int CNT_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_strobe,
    input  logic               ack_valid,
    input  logic               ack_ok,
    input  logic               q_empty,
    input  logic [LBL_W-1:0]   head_label,
    input  logic [OCC_W-1:0]   head_ncells,
    input  logic [BYTES_W-1:0] head_tail_bytes,
    output logic               q_pop,
    output logic               rel_en,
    output logic [OCC_W-1:0]   rel_cells,
    output logic               tx_valid,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic               tx_tail,
    output logic [LBL_W-1:0]   tx_label,
    output logic [OCC_W-1:0]   tx_cell_idx,
    output logic [BYTES_W-1:0] tx_bytes,
    output logic [CNT_W-1:0]   retx_count
);
    localparam int BL_W = $clog2(BURST_CELLS + 1);

    tx_state_e       state, state_n;
    logic [OCC_W-1:0] done;
    logic [BL_W-1:0]  burst_len;
    logic [BL_W-1:0]  pos;
    logic [OCC_W-1:0] remaining;
    logic [BL_W-1:0]  pick;
    logic [OCC_W-1:0] acked_after;
    logic [OCC_W-1:0] idx_now;
    logic             last_in_burst;
    logic             answered;

    always_comb begin
        remaining     = head_ncells - done;
        pick          = (remaining > OCC_W'(BURST_CELLS)) ? BL_W'(BURST_CELLS) : BL_W'(remaining);
        acked_after   = done + OCC_W'(burst_len);
        idx_now       = done + OCC_W'(pos);
        last_in_burst = (pos == burst_len - BL_W'(1));
        answered      = (state == ST_WAIT) && ack_valid;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (slot_strobe && !q_empty) state_n = ST_SEND;
            ST_SEND: if (last_in_burst)           state_n = ST_WAIT;
            ST_WAIT: if (ack_valid)               state_n = ST_IDLE;
            default:                              state_n = ST_IDLE;
        endcase
    end

    // state register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            done       <= '0;
            burst_len  <= '0;
            pos        <= '0;
            retx_count <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && state_n == ST_SEND) begin
                burst_len <= pick;
                pos       <= '0;
            end
            if (state == ST_SEND) pos <= pos + BL_W'(1);
            if (answered) begin
                if (ack_ok) done <= (acked_after == head_ncells) ? '0 : acked_after;
                else        retx_count <= retx_count + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid    = (state == ST_SEND);
        tx_sop      = tx_valid && (pos == '0);
        tx_eop      = tx_valid && last_in_burst;
        tx_tail     = tx_valid && (idx_now == head_ncells - OCC_W'(1));
        tx_label    = tx_valid ? head_label : '0;
        tx_cell_idx = tx_valid ? idx_now : '0;
        tx_bytes    = !tx_valid ? '0 : (tx_tail ? head_tail_bytes : BYTES_W'(CELL_BYTES));
        rel_en      = answered && ack_ok;
        rel_cells   = OCC_W'(burst_len);
        q_pop       = rel_en && (acked_after == head_ncells);
    end
endmodule

// File: rtl/cfc_flow_ctrl.sv
module cfc_flow_ctrl #(
    parameter int LBL_W       = 6,
    parameter int LEN_W       = 16,
    parameter int CELL_BYTES  = 1500,
    parameter int BUF_BYTES   = 50000,
    parameter int BURST_CELLS = 5,
    parameter int QDEPTH      = 8,
    parameter int CNT_W       = 16,
    localparam int BUF_CELLS  = BUF_BYTES / CELL_BYTES,
    localparam int OCC_W      = $clog2(BUF_CELLS + 1),
    localparam int BYTES_W    = $clog2(CELL_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [LBL_W-1:0]   pkt_label,
    input  logic               slot_strobe,
    input  logic               ack_valid,
    input  logic               ack_ok,
    output logic               tx_valid,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic               tx_tail,
    output logic [LBL_W-1:0]   tx_label,
    output logic [OCC_W-1:0]   tx_cell_idx,
    output logic [BYTES_W-1:0] tx_bytes,
    output logic [OCC_W-1:0]   cells_used,
    output logic [CNT_W-1:0]   drop_count,
    output logic [CNT_W-1:0]   retx_count
);
    localparam int ENT_W = LBL_W + OCC_W + BYTES_W;

    logic               accept, drop;
    logic [OCC_W-1:0]   new_cells;
    logic [BYTES_W-1:0] new_tail;
    logic [ENT_W-1:0]   head;
    logic               q_empty, q_full, q_pop;
    logic               rel_en;
    logic [OCC_W-1:0]   rel_cells;
    logic [OCC_W-1:0]   add_c, sub_c;

    cfc_admit #(
        .LEN_W(LEN_W), .CELL_BYTES(CELL_BYTES), .BUF_CELLS(BUF_CELLS),
        .OCC_W(OCC_W), .BYTES_W(BYTES_W)
    ) admit_i (
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .used(cells_used), .q_full(q_full),
        .accept(accept), .drop(drop), .ncells(new_cells), .tail_bytes(new_tail)
    );

    cfc_pkt_queue #(.DEPTH(QDEPTH), .W(ENT_W)) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_data({pkt_label, new_cells, new_tail}),
        .pop(q_pop), .head(head), .empty(q_empty), .full(q_full)
    );

    cfc_sender #(
        .LBL_W(LBL_W), .OCC_W(OCC_W), .BYTES_W(BYTES_W), .CELL_BYTES(CELL_BYTES),
        .BURST_CELLS(BURST_CELLS), .CNT_W(CNT_W)
    ) sender_i (
        .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .q_empty(q_empty),
        .head_label(head[ENT_W-1 -: LBL_W]),
        .head_ncells(head[BYTES_W +: OCC_W]),
        .head_tail_bytes(head[BYTES_W-1:0]),
        .q_pop(q_pop), .rel_en(rel_en), .rel_cells(rel_cells),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_tail(tx_tail),
        .tx_label(tx_label), .tx_cell_idx(tx_cell_idx), .tx_bytes(tx_bytes),
        .retx_count(retx_count)
    );

    always_comb begin
        add_c = accept ? new_cells : '0;
        sub_c = rel_en ? rel_cells : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_used <= '0;
            drop_count <= '0;
        end else begin
            cells_used <= cells_used + add_c - sub_c;
            if (drop) drop_count <= drop_count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cfc_flow_ctrl_chk.sv
module cfc_flow_ctrl_chk #(
    parameter int BUF_CELLS  = 33,
    parameter int CELL_BYTES = 1500,
    parameter int LBL_W      = 6,
    parameter int OCC_W      = 6,
    parameter int BYTES_W    = 11,
    parameter int CNT_W      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic               ack_valid,
    input logic               ack_ok,
    input logic               tx_valid,
    input logic               tx_sop,
    input logic               tx_eop,
    input logic               tx_tail,
    input logic [LBL_W-1:0]   tx_label,
    input logic [BYTES_W-1:0] tx_bytes,
    input logic [OCC_W-1:0]   cells_used,
    input logic [CNT_W-1:0]   drop_count,
    input logic [CNT_W-1:0]   retx_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cells_used) <= BUF_CELLS); // R3

    AST_FULL_CELL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_tail) |-> (int'(tx_bytes) == CELL_BYTES)); // R1

    AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_eop) |=> (tx_valid && !tx_sop && $stable(tx_label))); // R2

    AST_QUIET_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_eop) |=> !tx_valid); // R7

    AST_RETX_ONLY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid || ack_ok) |=> $stable(retx_count)); // R6

    AST_DROP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> $stable(drop_count)); // R4
endmodule

bind cfc_flow_ctrl cfc_flow_ctrl_chk #(
    .BUF_CELLS(BUF_CELLS), .CELL_BYTES(CELL_BYTES), .LBL_W(LBL_W),
    .OCC_W(OCC_W), .BYTES_W(BYTES_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_tail(tx_tail), .tx_label(tx_label), .tx_bytes(tx_bytes),
    .cells_used(cells_used), .drop_count(drop_count), .retx_count(retx_count)
);

// File: tb/cfc_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfc_flow_ctrl_tb_top;
    localparam int CELLB = 1500;
    localparam int CAP   = 33;
    localparam int BURST = 5;
    localparam int QMAX  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic [5:0]  pkt_label = '0;
    logic        slot_strobe = 1'b0;
    logic        ack_valid = 1'b0;
    logic        ack_ok = 1'b0;
    logic        tx_valid, tx_sop, tx_eop, tx_tail;
    logic [5:0]  tx_label, tx_cell_idx, cells_used;
    logic [10:0] tx_bytes;
    logic [15:0] drop_count, retx_count;

    always #2.5 clk = ~clk;

    cfc_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_label(pkt_label), .slot_strobe(slot_strobe), .ack_valid(ack_valid),
        .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_tail(tx_tail), .tx_label(tx_label), .tx_cell_idx(tx_cell_idx),
        .tx_bytes(tx_bytes), .cells_used(cells_used), .drop_count(drop_count),
        .retx_count(retx_count)
    );

    typedef struct {
        int lab; int idx; bit sop; bit eop; bit tail; int bytes;
    } cell_t;

    cell_t sb[$];
    cell_t e;
    int n_chk = 0, n_fail = 0;
    int mq_len[$];
    int mq_lab[$];
    int mdone = 0, mused = 0, mdrop = 0, mretx = 0, mburst = 0;
    bit m_wait = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int ncell(input int len);
        return (len + CELLB - 1) / CELLB;
    endfunction

    // monitor: compare every transmitted cell with the scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected cell", int'(tx_cell_idx), -1);
            end else begin
                e = sb.pop_front();
                check(int'(tx_label) == e.lab, "R10 label", int'(tx_label), e.lab);
                check(int'(tx_cell_idx) == e.idx, "R1 cell index", int'(tx_cell_idx), e.idx);
                check(tx_sop == e.sop && tx_eop == e.eop, "R2 sop/eop",
                      int'({tx_sop, tx_eop}), int'({e.sop, e.eop}));
                check(tx_tail == e.tail, "R1 tail flag", int'(tx_tail), int'(e.tail));
                check(int'(tx_bytes) == e.bytes, "R1 tail bytes", int'(tx_bytes), e.bytes);
            end
        end
    end

    // one stimulus cycle; len < 0 means no descriptor
    task automatic drive(input bit s, input bit a, input bit ok, input int len,
                         input int lab, input string tag);
        bit start;
        int n;
        cell_t c;
        start = 1'b0;
        @(negedge clk);
        slot_strobe = s;
        ack_valid   = a;
        ack_ok      = ok;
        pkt_valid   = (len >= 0);
        pkt_len     = (len >= 0) ? 16'(len) : '0;
        pkt_label   = 6'(lab);
        if (s && !m_wait && mq_len.size() > 0) begin
            start  = 1'b1;
            n      = ncell(mq_len[0]);
            mburst = (n - mdone > BURST) ? BURST : n - mdone;
            for (int i = 0; i < mburst; i++) begin
                c.lab   = mq_lab[0];
                c.idx   = mdone + i;
                c.sop   = (i == 0);
                c.eop   = (i == mburst - 1);
                c.tail  = (mdone + i == n - 1);
                c.bytes = c.tail ? mq_len[0] - (n - 1) * CELLB : CELLB;
                sb.push_back(c);
            end
        end
        if (len > 0) begin
            n = ncell(len);
            if (n <= CAP - mused && mq_len.size() < QMAX) begin
                mq_len.push_back(len);
                mq_lab.push_back(lab);
                mused += n;
            end else begin
                mdrop++;
            end
        end
        if (a && m_wait) begin
            if (ok) begin
                mused -= mburst;
                mdone += mburst;
                if (mdone == ncell(mq_len[0])) begin
                    void'(mq_len.pop_front());
                    void'(mq_lab.pop_front());
                    mdone = 0;
                end
            end else begin
                mretx++;
            end
            m_wait = 1'b0;
        end
        @(negedge clk);
        slot_strobe = 1'b0;
        ack_valid   = 1'b0;
        pkt_valid   = 1'b0;
        check(int'(cells_used) == mused, {tag, " cells_used"}, int'(cells_used), mused);
        check(int'(drop_count) == mdrop, {tag, " drop_count"}, int'(drop_count), mdrop);
        check(int'(retx_count) == mretx, {tag, " retx_count"}, int'(retx_count), mretx);
        if (start) begin
            repeat (mburst - 1) @(negedge clk);
            m_wait = 1'b1;
        end
    endtask

    task automatic drain(input string tag);
        while (mq_len.size() > 0) begin
            drive(1'b1, 1'b0, 1'b0, -1, 0, tag);
            drive(1'b0, 1'b1, 1'b1, -1, 0, tag);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0, "R9 tx_valid in reset", int'(tx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R9 tx_valid", int'(tx_valid), 0);
        check(cells_used == '0, "R9 cells_used", int'(cells_used), 0);
        check(drop_count == '0 && retx_count == '0, "R9 counters",
              int'(drop_count) + int'(retx_count), 0);

        drive(1'b0, 1'b1, 1'b0, -1, 0, "R7 ack in idle");
        drive(1'b0, 1'b0, 1'b0, 3000, 5, "R3 admit 2 cells");
        drive(1'b0, 1'b0, 1'b0, 8000, 9, "R3 admit 6 cells");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R2 first burst");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R7 slot in wait");
        check(tx_valid == 1'b0, "R7 no tx after slot in wait", int'(tx_valid), 0);
        drive(1'b0, 1'b1, 1'b0, -1, 0, "R6 nack");
        drive(1'b0, 1'b1, 1'b1, -1, 0, "R7 ack in idle after nack");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R6 resend");
        drive(1'b1, 1'b1, 1'b1, -1, 0, "R5 ack with slot");
        check(tx_valid == 1'b0, "R7 slot with answer starts nothing", int'(tx_valid), 0);
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R2 five cell burst");
        drive(1'b0, 1'b1, 1'b1, -1, 0, "R5 partial release");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R1 tail burst");
        drive(1'b0, 1'b1, 1'b1, -1, 0, "R5 release tail");

        drive(1'b0, 1'b0, 1'b0, 49500, 12, "R3 fill to 33");
        drive(1'b0, 1'b0, 1'b0, 1, 13, "R4 drop when full");
        drive(1'b0, 1'b0, 1'b0, 0, 14, "R4 zero length ignored");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R2 burst of big packet");
        drive(1'b0, 1'b1, 1'b1, 1500, 15, "R8 drop despite release");
        drive(1'b1, 1'b0, 1'b0, -1, 0, "R2 next burst");
        drive(1'b0, 1'b1, 1'b1, 7500, 16, "R8 admit with release");
        drive(1'b0, 1'b0, 1'b0, 65535, 17, "R4 oversize drop");
        drain("R10 drain");

        for (int k = 0; k < QMAX; k++) drive(1'b0, 1'b0, 1'b0, 100, 20 + k, "R3 small packets");
        drive(1'b0, 1'b0, 1'b0, 100, 28, "R4 queue full drop");
        drain("R10 order");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all expected cells seen", sb.size(), 0);
        check(tx_valid == 1'b0, "R10 idle at end", int'(tx_valid), 0);
        summary();
        $finish;
    end
endmodule